// File: doc/BRIEF.md
# Bus Wait-State Timing Generator

The block sits beside a processor's memory port and tells it, for every access, how many clock cycles that access must stall. The memory map is split into sixteen regions selected by address bits 27:24. Three cartridge ROM windows each take two adjacent regions (8/9, 10/11, 12/13), and region 14 is the cartridge SRAM window. Their timings come from a 16-bit wait-control register. External work RAM in region 2 has a fixed timing. All other regions run with no wait at all.

For each request the requester presents the address, the access width (16 or 32 bits) and a flag marking a sequential (burst) access. It keeps the request held until `acc_ready` is seen high. The block computes a stall count from the region's first-access wait N and burst wait S, then holds `acc_ready` low for exactly that many cycles. The control register can be rewritten at any time. A new value governs the next accepted request and never an access that is already stalling. Bit 14 (prefetch enable) is stored and can be read back, but it has no effect on timing.

Top module: `bus_wait_gen`

## Requirements
- R1: After a synchronous reset the control register reads 0x0000, `acc_ready` is high while no request is present, and the ROM windows use a first-access wait of 4 and burst waits of 2, 4 and 8 (windows 0, 1, 2).
- R2: A request to any region other than 2 and 8..14 sees `acc_ready` high in the same cycle it is presented.
- R3: A ROM window's 2-bit first-access field maps code 0→4, 1→3, 2→2, 3→8 wait cycles. The field sits at bits 3:2 for window 0 (regions 8/9), bits 6:5 for window 1 (10/11) and bits 9:8 for window 2 (12/13). A non-sequential 16-bit access stalls N cycles.
- R4: A sequential 16-bit ROM access stalls S cycles. S is selected by bit 4 (window 0: 0→2, 1→1), bit 7 (window 1: 0→4, 1→1) and bit 10 (window 2: 0→8, 1→1).
- R5: A 32-bit ROM access stalls N+S+1 cycles when non-sequential and 2S+1 cycles when sequential.
- R6: Region 14 uses the code of bits 1:0 with the R3 mapping as N for both access kinds. A 16-bit access stalls N cycles and a 32-bit access stalls 2N+1 cycles.
- R7: Region 2 stalls 2 cycles for any 16-bit access and 5 cycles for any 32-bit access.
- R8: Both regions of a ROM window give identical stall counts.
- R9: An accepted request with count W holds `acc_ready` low in its first cycle and the next W-1 cycles, and raises it in cycle W. Changes of address, width or sequential flag during the stall do not alter W.
- R10: A control write issued while an access stalls leaves that access's count unchanged. The next accepted request uses the new value.
- R11: A control write is visible on `cfg_rdata` in the following cycle. The prefetch-enable bit 14 does not change any stall count.
- R12: Address bits outside 27:24 do not influence the stall count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the wait-control register |
| cfg_wdata | input | 16 | New wait-control value |
| cfg_rdata | output | 16 | Current wait-control value |
| acc_req | input | 1 | Access request, held until `acc_ready` |
| acc_addr | input | 32 | Access address; bits 27:24 select the region |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| acc_seq | input | 1 | 1 = sequential (burst) access |
| acc_ready | output | 1 | Low while the current access stalls |

## Verification
A wrong decoded field or a wrong stall counter shows up as an `acc_ready` edge placed one or more cycles early or late. The first access that touches the affected region and width reveals it, because the ready edge is compared every cycle against a reference model. A counter that fails to clear leaves `acc_ready` low across the next request, and the following compare catches it. A register that loses a write is seen one cycle later on `cfg_rdata`. A stall count latched at the wrong moment only shows when the control register or address is changed during a stall, so those cases are driven on purpose.

// File: rtl/wst_pkg.sv
package wst_pkg;

  // Largest count is 2*8+1 = 17, so five bits suffice.
  localparam int unsigned WCNT_W = 5;

  typedef logic [WCNT_W-1:0] wcnt_t;

  typedef struct packed {
    wcnt_t first;   // non-sequential wait N
    wcnt_t burst;   // sequential wait S
  } wtiming_t;

  function automatic wcnt_t first_code_to_wait(input logic [1:0] code);
    case (code)
      2'd0:    return wcnt_t'(4);
      2'd1:    return wcnt_t'(3);
      2'd2:    return wcnt_t'(2);
      default: return wcnt_t'(8);
    endcase
  endfunction

  function automatic wcnt_t access_cost(input wtiming_t t, input logic wide,
                                        input logic seq);
    if (!wide) begin
      return seq ? t.burst : t.first;
    end
    if (seq) begin
      return wcnt_t'({t.burst, 1'b1});
    end
    return t.first + t.burst + wcnt_t'(1);
  endfunction

endpackage

// File: rtl/wst_cfg_reg.sv
module wst_cfg_reg
  import wst_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int N_WIN = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [CFG_W-1:0]             wdata,
  output logic [CFG_W-1:0]             q,
  output wtiming_t [N_WIN-1:0]         win_tm,
  output wtiming_t                     sram_tm
);

  localparam int FIELD_BASE   = 2;
  localparam int FIELD_STRIDE = 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= wdata;
    end
  end

  // Each window owns a 2-bit first-access code followed by a burst bit.
  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    localparam int FLSB   = FIELD_BASE + FIELD_STRIDE * k;
    localparam int BBIT   = FLSB + 2;
    localparam int LONG_S = 2 << k;
    assign win_tm[k].first = first_code_to_wait(q[FLSB +: 2]);
    assign win_tm[k].burst = q[BBIT] ? wcnt_t'(1) : wcnt_t'(LONG_S);
  end

  assign sram_tm.first = first_code_to_wait(q[1:0]);
  assign sram_tm.burst = sram_tm.first;

endmodule

// File: rtl/wst_cost.sv
module wst_cost
  import wst_pkg::*;
#(
  parameter int RGN_W     = 4,
  parameter int N_WIN     = 3,
  parameter int WIN_BASE  = 8,
  parameter int SRAM_RGN  = 14,
  parameter int XRAM_RGN  = 2,
  parameter int XRAM_WAIT = 2
) (
  input  logic [RGN_W-1:0]     rgn,
  input  logic                 wide,
  input  logic                 seq,
  input  wtiming_t [N_WIN-1:0] win_tm,
  input  wtiming_t             sram_tm,
  output wcnt_t                cost
);

  wtiming_t sel;
  logic     hit;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    if (rgn == RGN_W'(XRAM_RGN)) begin
      sel.first = wcnt_t'(XRAM_WAIT);
      sel.burst = wcnt_t'(XRAM_WAIT);
      hit       = 1'b1;
    end
    if (rgn == RGN_W'(SRAM_RGN)) begin
      sel = sram_tm;
      hit = 1'b1;
    end
    for (int k = 0; k < N_WIN; k++) begin
      if (rgn == RGN_W'(WIN_BASE + 2 * k) || rgn == RGN_W'(WIN_BASE + 2 * k + 1)) begin
        sel = win_tm[k];
        hit = 1'b1;
      end
    end
    cost = hit ? access_cost(sel, wide, seq) : '0;
  end

endmodule

// File: rtl/wst_stall.sv
module wst_stall
  import wst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  input  wcnt_t cost,
  output logic  ready
);

  logic  busy;
  wcnt_t left;

  // Idle: a zero-cost request completes at once. Stalling: ready when the count runs out.
  always_comb begin
    if (busy) begin
      ready = (left == '0);
    end else begin
      ready = !(req && cost != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        left <= left - wcnt_t'(1);
      end
    end else if (req && cost != '0) begin
      busy <= 1'b1;
      left <= cost - wcnt_t'(1);
    end
  end

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import wst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RGN_LSB   = 24,
  parameter int RGN_W     = 4,
  parameter int CFG_W     = 16,
  parameter int N_WIN     = 3,
  parameter int WIN_BASE  = 8,
  parameter int SRAM_RGN  = 14,
  parameter int XRAM_RGN  = 2,
  parameter int XRAM_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wide,
  input  logic              acc_seq,
  output logic              acc_ready
);

  wtiming_t [N_WIN-1:0] win_tm;
  wtiming_t             sram_tm;
  wcnt_t                cost;
  logic [RGN_W-1:0]     rgn;

  assign rgn = acc_addr[RGN_LSB +: RGN_W];

  wst_cfg_reg #(.CFG_W(CFG_W), .N_WIN(N_WIN)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .q      (cfg_rdata),
    .win_tm (win_tm),
    .sram_tm(sram_tm)
  );

  wst_cost #(
    .RGN_W(RGN_W), .N_WIN(N_WIN), .WIN_BASE(WIN_BASE),
    .SRAM_RGN(SRAM_RGN), .XRAM_RGN(XRAM_RGN), .XRAM_WAIT(XRAM_WAIT)
  ) u_cost (
    .rgn    (rgn),
    .wide   (acc_wide),
    .seq    (acc_seq),
    .win_tm (win_tm),
    .sram_tm(sram_tm),
    .cost   (cost)
  );

  wst_stall u_stall (
    .clk  (clk),
    .rst  (rst),
    .req  (acc_req),
    .cost (cost),
    .ready(acc_ready)
  );

endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              acc_req,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wide,
  input logic              acc_seq,
  input logic              acc_ready
);

  localparam int MAX_STALL = 17;

  logic       armed = 1'b0;
  logic [5:0] low_run;
  logic [3:0] rgn;
  logic       zero_rgn;

  assign rgn      = acc_addr[27:24];
  assign zero_rgn = !(rgn == 4'd2 || (rgn >= 4'd8 && rgn <= 4'd14));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      low_run <= '0;
    end else begin
      armed   <= 1'b1;
      low_run <= acc_ready ? '0 : low_run + 6'd1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> cfg_rdata == '0);

  // R11
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R2
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (acc_req && zero_rgn && $past(acc_ready)) |-> acc_ready);

  // R7
  xram_half_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (acc_req && rgn == 4'd2 && !acc_wide && $past(acc_ready))
      |-> !acc_ready ##1 !acc_ready ##1 acc_ready);

  // R9
  stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
    low_run <= 6'(MAX_STALL));

endmodule

bind bus_wait_gen bus_wait_gen_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .acc_req  (acc_req),
  .acc_addr (acc_addr),
  .acc_wide (acc_wide),
  .acc_seq  (acc_seq),
  .acc_ready(acc_ready)
);

// File: tb/test_bus_wait_gen.sv
`timescale 1ns/1ps
module test_bus_wait_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        acc_req = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_wide = 1'b0;
  logic        acc_seq = 1'b0;
  logic        acc_ready;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_wait_gen i_bus_wait_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_wide(acc_wide), .acc_seq(acc_seq), .acc_ready(acc_ready)
  );

  // Spec-level timing: first-access code table and the cost rules.
  function automatic int code_wait(input int c);
    case (c)
      0: return 4;
      1: return 3;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_wait(input logic [15:0] c, input logic [31:0] a,
                                  input bit wide, input bit seq);
    int r = int'(a[27:24]);
    int n;
    int s;
    if (r == 2) begin
      n = 2; s = 2;
    end else if (r == 14) begin
      n = code_wait(int'(c[1:0])); s = n;
    end else if (r >= 8 && r <= 13) begin
      int k = (r - 8) / 2;
      n = code_wait(int'(c[2 + 3 * k +: 2]));
      s = c[4 + 3 * k] ? 1 : (2 << k);
    end else begin
      return 0;
    end
    if (!wide) return seq ? s : n;
    return seq ? 2 * s + 1 : n + s + 1;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Per-cycle reference: remaining low cycles of the access in flight.
  logic [15:0] m_cfg;
  bit          m_armed = 1'b0;
  bit          m_stall = 1'b0;
  int          m_left = 0;

  always @(negedge clk) begin
    int w;
    if (!rst && m_armed) begin
      w = exp_wait(m_cfg, acc_addr, acc_wide, acc_seq);
      chk("R9 cycle", int'(acc_ready),
          m_stall ? int'(m_left == 0) : int'(!(acc_req && w != 0)));
      if (m_stall) begin
        if (m_left == 0) m_stall = 1'b0;
        else m_left--;
      end else if (acc_req && w != 0) begin
        m_stall = 1'b1;
        m_left = w - 1;
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
    if (rst) begin
      m_armed = 1'b1;
      m_stall = 1'b0;
      m_cfg = '0;
    end
  end

  logic [15:0] b_cfg = '0;

  task automatic cfg_write(input logic [15:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    b_cfg = v;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input bit wide,
                        input bit seq);
    int n = 0;
    int exp = exp_wait(b_cfg, a, wide, seq);
    @(posedge clk); #1;
    acc_req = 1'b1; acc_addr = a; acc_wide = wide; acc_seq = seq;
    forever begin
      @(negedge clk);
      if (acc_ready) break;
      n++;
    end
    @(posedge clk); #1;
    acc_req = 1'b0;
    chk(tag, n, exp);
  endtask

  function automatic string tag_for(input int r, input bit wide, input bit seq);
    if (r == 14) return "R6";
    if (wide) return "R5";
    if (seq) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 ready idle", int'(acc_ready), 1);
    chk("R1 cfg zero", int'(cfg_rdata), 0);

    // Reset timings
    access("R1 win0 first", 32'h0800_0000, 1'b0, 1'b0);
    chk("R1 literal", exp_wait(16'h0, 32'h0800_0000, 1'b0, 1'b0), 4);
    access("R1 win0 burst", 32'h0800_0010, 1'b0, 1'b1);
    access("R1 win1 burst", 32'h0A00_0000, 1'b0, 1'b1);
    access("R1 win2 burst", 32'h0C00_0000, 1'b0, 1'b1);
    access("R5 win0 32 first", 32'h0800_0000, 1'b1, 1'b0);
    access("R5 win2 32 first", 32'h0D00_0000, 1'b1, 1'b0);
    access("R5 win1 32 seq", 32'h0B00_0000, 1'b1, 1'b1);

    // Zero-wait regions
    access("R2 region0", 32'h0000_0100, 1'b1, 1'b0);
    access("R2 region3", 32'h0300_0000, 1'b0, 1'b1);
    access("R2 region6", 32'h0600_0000, 1'b1, 1'b1);
    access("R2 region15", 32'h0F00_0000, 1'b0, 1'b0);

    // External work RAM
    access("R7 xram 16", 32'h0200_0000, 1'b0, 1'b0);
    access("R7 xram 16 seq", 32'h0200_0000, 1'b0, 1'b1);
    access("R7 xram 32", 32'h0200_0000, 1'b1, 1'b0);
    access("R7 xram 32 seq", 32'h0200_0000, 1'b1, 1'b1);

    // SRAM at reset
    access("R6 sram 16", 32'h0E00_0000, 1'b0, 1'b1);
    access("R6 sram 32", 32'h0E00_0000, 1'b1, 1'b0);

    // Upper address bits ignored
    access("R12 high bits", 32'hF800_0000, 1'b1, 1'b0);
    access("R12 high bits zero", 32'hA100_0000, 1'b1, 1'b0);

    // Several control values across all windows
    foreach (b_cfg[i]) begin end
    for (int v = 0; v < 4; v++) begin
      logic [15:0] cv;
      case (v)
        0: cv = 16'h0495;
        1: cv = 16'h032A;
        2: cv = 16'h07FF;
        default: cv = 16'h0166;
      endcase
      cfg_write(cv);
      chk("R11 readback", int'(cfg_rdata), int'(cv));
      for (int r = 8; r <= 14; r++) begin
        for (int m = 0; m < 4; m++) begin
          access(tag_for(r, m[1], m[0]), {4'h0, 4'(r), 24'h000040}, m[1], m[0]);
        end
      end
      access("R8 pair even", 32'h0A00_0000, 1'b1, 1'b0);
      access("R8 pair odd", 32'h0B00_0000, 1'b1, 1'b0);
    end

    // Prefetch bit stored, no timing effect
    cfg_write(16'h4000);
    chk("R11 prefetch readback", int'(cfg_rdata), 16'h4000);
    access("R11 prefetch no effect", 32'h0800_0000, 1'b0, 1'b0);
    chk("R11 literal", exp_wait(16'h4000, 32'h0800_0000, 1'b0, 1'b0), 4);

    // Control write during a stall
    cfg_write(16'h0000);
    fork
      access("R10 running count", 32'h0C00_0000, 1'b1, 1'b0);
      begin
        repeat (3) @(posedge clk);
        #1 cfg_we = 1'b1; cfg_wdata = 16'h07FF;
        @(posedge clk); #1 cfg_we = 1'b0;
      end
    join
    b_cfg = 16'h07FF;
    access("R10 next request", 32'h0C00_0000, 1'b1, 1'b0);

    // Address change during a stall
    cfg_write(16'h0000);
    fork
      access("R9 addr change", 32'h0A00_0000, 1'b1, 1'b1);
      begin
        repeat (3) @(posedge clk);
        #2 acc_addr = 32'h0000_0000; acc_wide = 1'b0;
      end
    join

    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule